// File: doc/BRIEF.md
# Privileged Register Access Checker with Masked Merge

This block sits between an instruction's register-access request and the storage that holds the processor's control registers. It takes a 12-bit register address, the hart's current privilege level, a debug-mode flag, an access kind (swap, bit-set or bit-clear) and a source operand. From these it decides whether the access is allowed. It fetches the old value through a plain combinational read port and folds the three access kinds into one masked merge. It then returns the old value together with an illegal-access flag and, when a write is due, a write strobe with the merged data.

Legality is derived mostly from the address itself: two bits give the lowest privilege allowed and two bits mark read-only registers. On top of that come two policy checks. The first gates user and supervisor reads of the counter windows through the AND of two per-counter enable masks. The second traps supervisor access to the address-translation register while the trap-translation control bit is set. Addresses the storage does not implement are also refused. A write to the translation register that carries an unsupported mode is dropped silently.

The block is a three-state machine. In `ST_IDLE` it waits for a request and asserts `req_ready`; a request accepted there moves it to `ST_LOOKUP`. `ST_LOOKUP` always moves on to `ST_RESP`. `ST_RESP` always returns to `ST_IDLE`. `ST_LOOKUP` reads storage and evaluates every check. `ST_RESP` presents the response for one cycle and, when the access is legal, issues the write.

Top module: `csr_acc_unit`

## Requirements
- R1: Privilege encoding is U=00, S=01, M=11. Address bits [9:8] give the lowest privilege that may access the register. A request whose privilege is numerically below it is illegal unless `req_debug` is 1.
- R2: Address bits [11:10] equal to 11 mark a read-only register. An access to one with a nonzero write mask is illegal. A set or clear with a zero operand is a legal read.
- R3: `req_kind` 00 is swap (new data = operand, mask = all ones), 01 is set (new data = all ones, mask = operand) and 10 is clear (new data = zero, mask = operand). Kind 11 is illegal.
- R4: The write data equals the old value with the bits chosen by the mask taken from the new data. A zero mask produces no write.
- R5: `resp_rdata` carries the value from before the write when the access is legal, and zero when it is illegal.
- R6: For addresses 0xC00..0xC1F and 0xC80..0xC9F, a request below M uses `ctr_en_m` as the enable; a request from U also ANDs in `ctr_en_s`. The access is illegal when the enable bit at address bits [4:0] is 0. M and debug requests are not bypassed by the debug flag, only M is ungated.
- R7: An access to address 0x180 from S while `xlat_trap` is 1 is illegal, regardless of the debug flag.
- R8: With XLEN=64, a write to 0x180 is dropped (no write, not illegal, old value returned) unless merged bits [63:60] hold 0, 8, 9 or 10.
- R9: An address for which storage reports `st_hit`=0 is illegal.
- R10: An illegal access never asserts `st_wr_en`.
- R11: `req_ready` is high only in `ST_IDLE`. `resp_valid` pulses for one cycle two clocks after acceptance. `st_wr_en` is only ever high together with `resp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted this cycle |
| req_addr | input | ADDR_W | Register address |
| req_kind | input | 2 | Access kind (R3) |
| req_priv | input | 2 | Current privilege level |
| req_debug | input | 1 | Debug mode, bypasses the privilege check |
| req_operand | input | XLEN | Source operand |
| ctr_en_m | input | CTR_W | Machine-level counter enable mask |
| ctr_en_s | input | CTR_W | Supervisor-level counter enable mask |
| xlat_trap | input | 1 | Trap-translation control bit |
| resp_valid | output | 1 | Response strobe |
| resp_illegal | output | 1 | Access refused |
| resp_rdata | output | XLEN | Old register value |
| st_addr | output | ADDR_W | Storage address |
| st_rd_data | input | XLEN | Storage read data, combinational on `st_addr` |
| st_hit | input | 1 | Storage implements `st_addr` |
| st_wr_en | output | 1 | Storage write strobe |
| st_wr_data | output | XLEN | Storage write data |

## Verification
The assertions assume that storage answers `st_rd_data` and `st_hit` combinationally from `st_addr`. They also assume that `ctr_en_m`, `ctr_en_s` and `xlat_trap` stay constant between acceptance and response. The stimulus meets this by changing those side inputs only while the block is idle and the previous response has been consumed. Requests are driven on the falling edge and held only until the edge that accepts them, so no request is ever presented while the machine is busy.

// File: rtl/csr_acc_pkg.sv
package csr_acc_pkg;

    typedef enum logic [1:0] {
        KIND_SWAP = 2'b00,
        KIND_SET  = 2'b01,
        KIND_CLR  = 2'b10,
        KIND_BAD  = 2'b11
    } acc_kind_e;

    localparam logic [1:0] PRIV_U = 2'b00;
    localparam logic [1:0] PRIV_S = 2'b01;
    localparam logic [1:0] PRIV_M = 2'b11;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_LOOKUP = 2'b01,
        ST_RESP   = 2'b10
    } acc_state_e;

    typedef struct packed {
        logic [1:0] min_priv;
        logic       read_only;
        logic       is_ctr;
        logic       is_xlat;
    } addr_info_t;

endpackage

// File: rtl/csr_acc_decode.sv
module csr_acc_decode
    import csr_acc_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int CTR_W       = 32,
    parameter int XLAT_ADDR   = 'h180,
    parameter int CTR_BASE_LO = 'hC00,
    parameter int CTR_BASE_HI = 'hC80
) (
    input  logic [ADDR_W-1:0] addr,
    output addr_info_t        info
);
    localparam int RO_MSB   = ADDR_W - 1;
    localparam int RO_LSB   = ADDR_W - 2;
    localparam int PRIV_MSB = ADDR_W - 3;
    localparam int PRIV_LSB = ADDR_W - 4;
    localparam logic [ADDR_W-1:0] SPAN_MASK = ADDR_W'(CTR_W - 1);
    localparam logic [ADDR_W-1:0] BASE_LO   = ADDR_W'(CTR_BASE_LO);
    localparam logic [ADDR_W-1:0] BASE_HI   = ADDR_W'(CTR_BASE_HI);
    localparam logic [ADDR_W-1:0] XLAT      = ADDR_W'(XLAT_ADDR);

    logic [ADDR_W-1:0] window;

    always_comb begin
        window         = addr & ~SPAN_MASK;
        info.min_priv  = addr[PRIV_MSB:PRIV_LSB];
        info.read_only = (addr[RO_MSB:RO_LSB] == 2'b11);
        info.is_ctr    = (window == BASE_LO) || (window == BASE_HI);
        info.is_xlat   = (addr == XLAT);
    end
endmodule

// File: rtl/csr_acc_merge.sv
module csr_acc_merge
    import csr_acc_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  acc_kind_e         kind,
    input  logic [XLEN-1:0]   operand,
    input  logic [XLEN-1:0]   old_val,
    output logic [XLEN-1:0]   new_val,
    output logic              mask_nz,
    output logic              mode_ok
);
    logic [XLEN-1:0] wmask;
    logic [XLEN-1:0] src;

    always_comb begin
        unique case (kind)
            KIND_SWAP: begin wmask = '1;      src = operand; end
            KIND_SET:  begin wmask = operand; src = '1;      end
            KIND_CLR:  begin wmask = operand; src = '0;      end
            default:   begin wmask = '0;      src = '0;      end
        endcase
        new_val = (old_val & ~wmask) | (src & wmask);
        mask_nz = |wmask;
    end

    generate
        if (XLEN == 64) begin : g_mode64
            logic [3:0] mode_fld;
            always_comb begin
                mode_fld = new_val[XLEN-1:XLEN-4];
                mode_ok  = (mode_fld == 4'd0) || (mode_fld == 4'd8) ||
                           (mode_fld == 4'd9) || (mode_fld == 4'd10);
            end
        end else begin : g_mode_any
            // A one-bit mode field has no unsupported encoding.
            assign mode_ok = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/csr_acc_legality.sv
module csr_acc_legality
    import csr_acc_pkg::*;
#(
    parameter int CTR_W = 32,
    localparam int CTR_IDX_W = $clog2(CTR_W)
) (
    input  addr_info_t           info,
    input  logic [CTR_IDX_W-1:0] ctr_idx,
    input  logic [1:0]           priv,
    input  logic                 debug,
    input  acc_kind_e            kind,
    input  logic                 mask_nz,
    input  logic                 hit,
    input  logic [CTR_W-1:0]     en_m,
    input  logic [CTR_W-1:0]     en_s,
    input  logic                 xlat_trap,
    output logic                 illegal
);
    logic [CTR_W-1:0] ctr_en;
    logic priv_fail, ro_fail, kind_fail, ctr_fail, xlat_fail;

    always_comb begin
        ctr_en = '1;
        if (priv != PRIV_M) ctr_en = ctr_en & en_m;
        if (priv == PRIV_U) ctr_en = ctr_en & en_s;

        priv_fail = !debug && (priv < info.min_priv);
        ro_fail   = info.read_only && mask_nz;
        kind_fail = (kind == KIND_BAD);
        ctr_fail  = info.is_ctr && !ctr_en[ctr_idx];
        xlat_fail = info.is_xlat && (priv == PRIV_S) && xlat_trap;

        illegal = !hit || priv_fail || ro_fail || kind_fail || ctr_fail || xlat_fail;
    end
endmodule

// File: rtl/csr_acc_unit.sv
module csr_acc_unit
    import csr_acc_pkg::*;
#(
    parameter int XLEN      = 64,
    parameter int ADDR_W    = 12,
    parameter int CTR_W     = 32,
    parameter int XLAT_ADDR = 'h180
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_kind,
    input  logic [1:0]        req_priv,
    input  logic              req_debug,
    input  logic [XLEN-1:0]   req_operand,
    input  logic [CTR_W-1:0]  ctr_en_m,
    input  logic [CTR_W-1:0]  ctr_en_s,
    input  logic              xlat_trap,
    output logic              resp_valid,
    output logic              resp_illegal,
    output logic [XLEN-1:0]   resp_rdata,
    output logic [ADDR_W-1:0] st_addr,
    input  logic [XLEN-1:0]   st_rd_data,
    input  logic              st_hit,
    output logic              st_wr_en,
    output logic [XLEN-1:0]   st_wr_data
);
    localparam int CTR_IDX_W = $clog2(CTR_W);

    acc_state_e        state, state_nx;
    logic [ADDR_W-1:0] addr_q;
    acc_kind_e         kind_q;
    logic [1:0]        priv_q;
    logic              dbg_q;
    logic [XLEN-1:0]   op_q;

    logic [XLEN-1:0]   res_rdata;
    logic              res_illegal;
    logic              res_wr;
    logic [XLEN-1:0]   res_wdata;

    addr_info_t        info;
    logic [XLEN-1:0]   merged;
    logic              mask_nz, mode_ok, illegal;
    logic              accept;

    assign accept = (state == ST_IDLE) && req_valid;

    csr_acc_decode #(
        .ADDR_W   (ADDR_W),
        .CTR_W    (CTR_W),
        .XLAT_ADDR(XLAT_ADDR)
    ) u_decode (
        .addr(addr_q),
        .info(info)
    );

    csr_acc_merge #(.XLEN(XLEN)) u_merge (
        .kind   (kind_q),
        .operand(op_q),
        .old_val(st_rd_data),
        .new_val(merged),
        .mask_nz(mask_nz),
        .mode_ok(mode_ok)
    );

    csr_acc_legality #(.CTR_W(CTR_W)) u_legal (
        .info     (info),
        .ctr_idx  (addr_q[CTR_IDX_W-1:0]),
        .priv     (priv_q),
        .debug    (dbg_q),
        .kind     (kind_q),
        .mask_nz  (mask_nz),
        .hit      (st_hit),
        .en_m     (ctr_en_m),
        .en_s     (ctr_en_s),
        .xlat_trap(xlat_trap),
        .illegal  (illegal)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transitions: IDLE->LOOKUP on accept, LOOKUP->RESP, RESP->IDLE
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (req_valid) state_nx = ST_LOOKUP;
            ST_LOOKUP: state_nx = ST_RESP;
            ST_RESP:   state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // Request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            kind_q <= KIND_SWAP;
            priv_q <= PRIV_M;
            dbg_q  <= 1'b0;
            op_q   <= '0;
        end else if (accept) begin
            addr_q <= req_addr;
            kind_q <= acc_kind_e'(req_kind);
            priv_q <= req_priv;
            dbg_q  <= req_debug;
            op_q   <= req_operand;
        end
    end

    // Result capture at the end of the lookup cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_rdata   <= '0;
            res_illegal <= 1'b0;
            res_wr      <= 1'b0;
            res_wdata   <= '0;
        end else if (state == ST_LOOKUP) begin
            res_rdata   <= illegal ? '0 : st_rd_data;
            res_illegal <= illegal;
            res_wr      <= !illegal && mask_nz && (!info.is_xlat || mode_ok);
            res_wdata   <= merged;
        end
    end

    // Outputs
    always_comb begin
        req_ready    = 1'b0;
        resp_valid   = 1'b0;
        resp_illegal = 1'b0;
        resp_rdata   = '0;
        st_wr_en     = 1'b0;
        st_addr      = addr_q;
        st_wr_data   = res_wdata;
        unique case (state)
            ST_IDLE:   req_ready = 1'b1;
            ST_LOOKUP: ;
            ST_RESP: begin
                resp_valid   = 1'b1;
                resp_illegal = res_illegal;
                resp_rdata   = res_rdata;
                st_wr_en     = res_wr;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/csr_acc_sva.sv
module csr_acc_sva
    import csr_acc_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic [1:0]        req_kind,
    input logic [1:0]        req_priv,
    input logic              req_debug,
    input logic [XLEN-1:0]   req_operand,
    input logic              resp_valid,
    input logic              resp_illegal,
    input logic [XLEN-1:0]   resp_rdata,
    input logic              st_hit,
    input logic              st_wr_en,
    input logic [XLEN-1:0]   st_wr_data
);
    logic [ADDR_W-1:0] c_addr;
    logic [1:0]        c_kind, c_priv;
    logic              c_dbg, c_look, c_hit;
    logic [XLEN-1:0]   c_op;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_addr <= '0; c_kind <= '0; c_priv <= 2'b11; c_dbg <= 1'b0;
            c_op <= '0; c_look <= 1'b0; c_hit <= 1'b1;
        end else begin
            c_look <= req_valid && req_ready;
            if (req_valid && req_ready) begin
                c_addr <= req_addr; c_kind <= req_kind; c_priv <= req_priv;
                c_dbg <= req_debug; c_op <= req_operand;
            end
            if (c_look) c_hit <= st_hit;
        end
    end

    a_r11_resp_latency: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> $past(req_valid && req_ready, 2));
    a_r11_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    a_r11_write_in_resp: assert property (@(posedge clk) disable iff (!rst_n)
        st_wr_en |-> resp_valid);
    a_r10_no_write_when_illegal: assert property (@(posedge clk) disable iff (!rst_n)
        resp_illegal |-> !st_wr_en);
    a_r1_low_priv: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !c_dbg && (c_priv < c_addr[ADDR_W-3:ADDR_W-4])) |-> resp_illegal);
    a_r2_read_only: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && (c_addr[ADDR_W-1:ADDR_W-2] == 2'b11) &&
         (c_kind == 2'b00 || ((c_kind != 2'b11) && (c_op != '0)))) |-> resp_illegal);
    a_r9_unimplemented: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !c_hit) |-> resp_illegal);
    a_r3_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr_en && c_kind == 2'b01) |-> ((st_wr_data & c_op) == c_op));
    a_r3_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr_en && c_kind == 2'b10) |-> ((st_wr_data & c_op) == '0));
    a_r5_illegal_zero: assert property (@(posedge clk) disable iff (!rst_n)
        resp_illegal |-> (resp_rdata == '0));
endmodule

bind csr_acc_unit csr_acc_sva #(.XLEN(XLEN), .ADDR_W(ADDR_W)) u_sva (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_kind(req_kind), .req_priv(req_priv),
    .req_debug(req_debug), .req_operand(req_operand), .resp_valid(resp_valid),
    .resp_illegal(resp_illegal), .resp_rdata(resp_rdata), .st_hit(st_hit),
    .st_wr_en(st_wr_en), .st_wr_data(st_wr_data)
);

// File: tb/csr_acc_unit_tb_top.sv
`timescale 1ns/1ps
module csr_acc_unit_tb_top;
    localparam int XLEN = 64;
    localparam int NREG = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [11:0]     req_addr = '0;
    logic [1:0]      req_kind = '0;
    logic [1:0]      req_priv = 2'b11;
    logic            req_debug = 1'b0;
    logic [XLEN-1:0] req_operand = '0;
    logic [31:0]     ctr_en_m = '1;
    logic [31:0]     ctr_en_s = '1;
    logic            xlat_trap = 1'b0;
    logic            resp_valid, resp_illegal, st_wr_en, st_hit;
    logic [XLEN-1:0] resp_rdata, st_rd_data, st_wr_data;
    logic [11:0]     st_addr;

    csr_acc_unit dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_kind(req_kind), .req_priv(req_priv),
        .req_debug(req_debug), .req_operand(req_operand), .ctr_en_m(ctr_en_m),
        .ctr_en_s(ctr_en_s), .xlat_trap(xlat_trap), .resp_valid(resp_valid),
        .resp_illegal(resp_illegal), .resp_rdata(resp_rdata), .st_addr(st_addr),
        .st_rd_data(st_rd_data), .st_hit(st_hit), .st_wr_en(st_wr_en),
        .st_wr_data(st_wr_data)
    );

    // Storage model
    logic [11:0]     reg_addr [NREG];
    logic [XLEN-1:0] reg_val  [NREG];
    logic [XLEN-1:0] shadow   [NREG];

    initial begin
        reg_addr[0] = 12'h300; reg_val[0] = 64'h1800;
        reg_addr[1] = 12'h340; reg_val[1] = 64'h0;
        reg_addr[2] = 12'h180; reg_val[2] = 64'h0;
        reg_addr[3] = 12'hC00; reg_val[3] = 64'h1111;
        reg_addr[4] = 12'hC02; reg_val[4] = 64'h2222;
        reg_addr[5] = 12'hC81; reg_val[5] = 64'h3333;
        reg_addr[6] = 12'h105; reg_val[6] = 64'hABCD;
        reg_addr[7] = 12'hF14; reg_val[7] = 64'h5;
        reg_addr[8] = 12'h001; reg_val[8] = 64'h1F;
        reg_addr[9] = 12'h140; reg_val[9] = 64'h0;
        for (int i = 0; i < NREG; i++) shadow[i] = reg_val[i];
    end

    always @* begin
        st_hit = 1'b0;
        st_rd_data = '0;
        for (int i = 0; i < NREG; i++)
            if (reg_addr[i] == st_addr) begin st_hit = 1'b1; st_rd_data = reg_val[i]; end
    end

    always @(posedge clk)
        if (st_wr_en)
            for (int i = 0; i < NREG; i++)
                if (reg_addr[i] == st_addr) reg_val[i] <= st_wr_data;

    // Scoreboard
    typedef struct packed {
        logic            illegal;
        logic            wr;
        logic [XLEN-1:0] rdata;
        logic [XLEN-1:0] wdata;
    } exp_t;
    exp_t  exp_q[$];
    string tag_q[$];
    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string tag, input string msg);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s", tag, msg);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && resp_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R11", "response with no pending request (actual 1 expected 0)");
            end else begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(resp_illegal == e.illegal && resp_rdata == e.rdata &&
                      st_wr_en == e.wr && (!e.wr || st_wr_data == e.wdata), t,
                      $sformatf("actual ill=%0b rd=%h we=%0b wd=%h expected ill=%0b rd=%h we=%0b wd=%h",
                                resp_illegal, resp_rdata, st_wr_en, st_wr_data,
                                e.illegal, e.rdata, e.wr, e.wdata));
            end
        end
    end

    // Expected result from the requirements
    task automatic model(input logic [11:0] a, input logic [1:0] k, input logic [1:0] p,
                         input logic d, input logic [XLEN-1:0] op, output exp_t e);
        int idx = -1;
        logic [XLEN-1:0] old_v, msk, nv, mrg;
        logic [31:0] en;
        logic ill;
        logic [3:0] md;
        for (int i = 0; i < NREG; i++) if (reg_addr[i] == a) idx = i;
        old_v = (idx >= 0) ? shadow[idx] : '0;
        ill = (idx < 0);                                         // R9
        if (k == 2'b11) ill = 1'b1;                              // R3
        if (!d && p < a[9:8]) ill = 1'b1;                        // R1
        msk = (k == 2'b00) ? '1 : (k == 2'b11 ? '0 : op);
        nv  = (k == 2'b00) ? op : (k == 2'b01 ? '1 : '0);
        if (a[11:10] == 2'b11 && msk != '0) ill = 1'b1;          // R2
        if (a[11:5] == 7'h60 || a[11:5] == 7'h64) begin          // R6
            en = '1;
            if (p != 2'b11) en = en & ctr_en_m;
            if (p == 2'b00) en = en & ctr_en_s;
            if (!en[a[4:0]]) ill = 1'b1;
        end
        if (a == 12'h180 && p == 2'b01 && xlat_trap) ill = 1'b1; // R7
        mrg = (old_v & ~msk) | (nv & msk);                       // R4
        md = mrg[63:60];
        e.illegal = ill;
        e.wr = !ill && msk != '0 &&
               !(a == 12'h180 && !(md == 0 || md == 8 || md == 9 || md == 10)); // R8
        e.rdata = ill ? '0 : old_v;                              // R5
        e.wdata = mrg;
        if (e.wr) shadow[idx] = mrg;
    endtask

    task automatic issue(input logic [11:0] a, input logic [1:0] k, input logic [1:0] p,
                         input logic d, input logic [XLEN-1:0] op, input string tag);
        exp_t e;
        @(negedge clk);
        while (!req_ready || resp_valid) @(negedge clk);
        model(a, k, p, d, op, e);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        req_addr = a; req_kind = k; req_priv = p; req_debug = d; req_operand = op;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  %0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            check(1'b0, "R11", "watchdog expired (actual hung, expected done)");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(req_ready == 1'b1 && resp_valid == 1'b0 && st_wr_en == 1'b0, "R11",
              $sformatf("reset outputs actual rdy=%0b rv=%0b we=%0b expected 1 0 0",
                        req_ready, resp_valid, st_wr_en));
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R11", $sformatf("idle ready actual %0b expected 1", req_ready));

        issue(12'h340, 2'b00, 2'b11, 1'b0, 64'hDEAD_BEEF_0123_4567, "R3 swap");
        issue(12'h340, 2'b01, 2'b11, 1'b0, 64'hF0, "R3 set");
        issue(12'h340, 2'b10, 2'b11, 1'b0, 64'hFF00_0000_0000_00FF, "R4 clear");
        issue(12'h340, 2'b01, 2'b11, 1'b0, 64'h0, "R4 zero mask");
        issue(12'h340, 2'b00, 2'b01, 1'b0, 64'h1, "R1 S to M");
        issue(12'h340, 2'b00, 2'b01, 1'b1, 64'h77, "R1 debug");
        issue(12'h105, 2'b00, 2'b00, 1'b0, 64'h4, "R1 U to S");
        issue(12'h105, 2'b00, 2'b01, 1'b0, 64'h4, "R1 S to S");
        issue(12'hF14, 2'b00, 2'b11, 1'b0, 64'h9, "R2 swap read-only");
        issue(12'hF14, 2'b10, 2'b11, 1'b0, 64'h0, "R2 zero-mask read");
        issue(12'h001, 2'b10, 2'b00, 1'b0, '1, "R4 user clear");
        issue(12'h7C0, 2'b00, 2'b11, 1'b0, 64'h1, "R9 unimplemented");
        issue(12'h340, 2'b11, 2'b11, 1'b0, 64'h1, "R3 bad kind");

        ctr_en_m = '1; ctr_en_s = 32'h0;
        issue(12'hC00, 2'b01, 2'b00, 1'b0, 64'h0, "R6 U blocked by s");
        ctr_en_s = 32'h1;
        issue(12'hC00, 2'b01, 2'b00, 1'b0, 64'h0, "R6 U allowed");
        ctr_en_m = 32'hFFFF_FFFB; ctr_en_s = '1;
        issue(12'hC02, 2'b01, 2'b01, 1'b0, 64'h0, "R6 S blocked by m");
        ctr_en_m = 32'h4; ctr_en_s = 32'h0;
        issue(12'hC02, 2'b01, 2'b01, 1'b0, 64'h0, "R6 S ignores s");
        ctr_en_m = 32'h0;
        issue(12'hC02, 2'b01, 2'b11, 1'b0, 64'h0, "R6 M ungated");
        issue(12'hC02, 2'b01, 2'b01, 1'b1, 64'h0, "R6 debug still gated");
        ctr_en_m = 32'h2; ctr_en_s = 32'h2;
        issue(12'hC81, 2'b10, 2'b00, 1'b0, 64'h0, "R6 high window");
        ctr_en_m = '1; ctr_en_s = '1;

        xlat_trap = 1'b1;
        issue(12'h180, 2'b00, 2'b01, 1'b0, 64'h8000_0000_0000_0123, "R7 S trapped");
        issue(12'h180, 2'b00, 2'b11, 1'b0, 64'h8000_0000_0000_0123, "R7 M not trapped");
        xlat_trap = 1'b0;
        issue(12'h180, 2'b00, 2'b01, 1'b0, 64'h9000_0000_0000_0456, "R7 S allowed");
        issue(12'h180, 2'b00, 2'b11, 1'b0, 64'h5000_0000_0000_0789, "R8 bad mode dropped");
        issue(12'h180, 2'b10, 2'b11, 1'b0, 64'hF000_0000_0000_0000, "R8 mode zero");
        issue(12'h180, 2'b01, 2'b11, 1'b0, 64'hA000_0000_0000_0000, "R8 mode ten");
        issue(12'h340, 2'b01, 2'b11, 1'b0, 64'h0, "R5 readback");

        repeat (6) @(negedge clk);
        check(exp_q.size() == 0, "R11",
              $sformatf("pending responses actual %0d expected 0", exp_q.size()));
        finish_run();
    end
endmodule